// File: doc/BRIEF.md
# Overlapping Serial 1101 Recognizer

This block watches a serial bit stream one qualified bit at a time and raises a detect flag in the same cycle as the final bit of every occurrence of the four-bit pattern 1,1,0,1. A valid strobe marks which clock cycles carry a bit. Cycles without the strobe are gaps in the stream and leave the recognizer untouched. Occurrences may share bits: the trailing 1 of one match counts as the leading 1 of the next. As a result, the stream 1101101 yields two detections.

The recognizer is a four-state Mealy machine. Its states record how much of the pattern has been seen so far: nothing, "1", "11" or "110". The detect output is a combinational function of the present state and the present input bit. A consumer therefore samples it on the same edge that accepts the bit.

Top module: `overlap_pattern_detector`

## Requirements
- R1: A synchronous active-high reset returns the machine to the nothing-seen state. Bits received before the reset cannot contribute to a later match.
- R2: In the nothing-seen state, a valid 0 keeps the state and a valid 1 moves to the seen-"1" state. Detect stays 0 in both cases.
- R3: In the seen-"1" state, a valid 1 moves to seen-"11" and a valid 0 returns to nothing-seen. Detect stays 0 in both cases.
- R4: In the seen-"11" state, a valid 0 moves to seen-"110". A valid 1 keeps the state, so any run of two or more 1s followed by 0,1 is a match. Detect stays 0.
- R5: In the seen-"110" state, a valid 1 drives detect to 1 and moves to seen-"1". A valid 0 returns to nothing-seen with detect 0.
- R6: Detect is combinational and is high in the same cycle as the bit that completes the pattern. It is high exactly when that valid bit is 1 and the three valid bits before it, oldest first, were 1,1,0.
- R7: While the valid strobe is low, detect is 0 and the state holds, whatever the data bit is.
- R8: Matches overlap. The stream 1101101 detects at bit positions 4 and 7, and 1101101101 detects at positions 4, 7 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes occur on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bitValid | input | 1 | High in cycles that carry a stream bit |
| bitIn | input | 1 | Serial data bit, used only when bitValid is high |
| detect | output | 1 | High for one cycle when the current bit completes 1101 |

## Verification
Directed streams take each state along both of its exits. These streams tell apart a return to nothing-seen from a hold in seen-"11", and a restart at seen-"1" from a restart at idle (1101101 and 1101101101 against 11101 and 111101). Resets inserted mid-pattern and strobe gaps inside a pattern separate true state holding from state loss. They also check that detect is never raised while the strobe is low, even when the data bit is 1. A long biased random stream with random gaps is compared against a four-bit history model. This model is built from the pattern definition and not from the state graph.

// File: rtl/pattern_det_pkg.sv
package pattern_det_pkg;

  localparam int STATE_W = 2;

  // Binary state encoding: the suffix of the pattern matched so far.
  typedef enum logic [STATE_W-1:0] {
    ST_NONE = 2'b00,
    ST_ONE  = 2'b01,
    ST_TWO  = 2'b10,
    ST_TAIL = 2'b11
  } recState_t;

  // Strobes passed from the control FSM to the output datapath.
  typedef struct packed {
    logic stepEn;     // a qualified bit is present this cycle
    logic tailReady;  // "110" has been seen; a 1 now completes the pattern
  } ctrlStrobe_t;

endpackage

// File: rtl/pattern_det_ctrl.sv
module pattern_det_ctrl
  import pattern_det_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bitValid,
  input  logic                 bitIn,
  output ctrlStrobe_t          strobes,
  output logic [STATE_W-1:0]   stateOut
);

  recState_t curState;
  recState_t nextState;

  always_comb begin
    nextState = curState;
    if (bitValid) begin
      unique case (curState)
        ST_NONE: nextState = bitIn ? ST_ONE : ST_NONE;
        ST_ONE:  nextState = bitIn ? ST_TWO : ST_NONE;
        ST_TWO:  nextState = bitIn ? ST_TWO : ST_TAIL;
        ST_TAIL: nextState = bitIn ? ST_ONE : ST_NONE;
        default: nextState = ST_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_NONE;
    else     curState <= nextState;
  end

  always_comb begin
    strobes.stepEn    = bitValid;
    strobes.tailReady = (curState == ST_TAIL);
  end

  assign stateOut = curState;

endmodule

// File: rtl/pattern_det_out.sv
module pattern_det_out
  import pattern_det_pkg::*;
(
  input  ctrlStrobe_t strobes,
  input  logic        bitIn,
  output logic        detect
);

  // Mealy output: present state (via strobe) and present bit.
  always_comb begin
    detect = strobes.stepEn & strobes.tailReady & bitIn;
  end

endmodule

// File: rtl/overlap_pattern_detector.sv
module overlap_pattern_detector
  import pattern_det_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bitValid,
  input  logic bitIn,
  output logic detect
);

  ctrlStrobe_t            strobes;
  logic [STATE_W-1:0]     curState;

  pattern_det_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .bitValid (bitValid),
    .bitIn    (bitIn),
    .strobes  (strobes),
    .stateOut (curState)
  );

  pattern_det_out u_out (
    .strobes (strobes),
    .bitIn   (bitIn),
    .detect  (detect)
  );

endmodule

// File: rtl/overlap_pattern_detector_chk.sv
module overlap_pattern_detector_chk (
  input logic       clk,
  input logic       rst,
  input logic       bitValid,
  input logic       bitIn,
  input logic       detect,
  input logic [1:0] curState
);

  // R1: reset lands in the nothing-seen state
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (curState == 2'b00));

  // R2: a 0 in the nothing-seen state stays there
  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bitValid && curState == 2'b00 && !bitIn) |=> (curState == 2'b00));

  // R3: a 0 after a single 1 returns to nothing-seen
  assert_one_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (bitValid && curState == 2'b01 && !bitIn) |=> (curState == 2'b00));

  // R4: extra 1s hold in the seen-"11" state
  assert_two_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (bitValid && curState == 2'b10 && bitIn) |=> (curState == 2'b10));

  // R5: a success restarts from seen-"1"
  assert_success_restart_R5: assert property (@(posedge clk) disable iff (rst)
    (bitValid && curState == 2'b11 && bitIn) |=> (curState == 2'b01));

  // R6: detect only from the tail state on a 1
  assert_detect_source_R6: assert property (@(posedge clk) disable iff (rst)
    detect |-> (curState == 2'b11 && bitIn && bitValid));

  // R7: gaps neither detect nor move the state
  assert_gap_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !bitValid |-> !detect);

  assert_gap_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !bitValid |=> $stable(curState));

endmodule

bind overlap_pattern_detector overlap_pattern_detector_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .bitValid (bitValid),
  .bitIn    (bitIn),
  .detect   (detect),
  .curState (curState)
);

// File: tb/overlap_pattern_detector_bench.sv
module overlap_pattern_detector_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitValid = 1'b0;
  logic bitIn = 1'b0;
  logic detect;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [2:0] hist = 3'b000;  // last three valid bits, newest in bit 0

  always #5 clk = ~clk;

  overlap_pattern_detector u_overlap_pattern_detector (
    .clk      (clk),
    .rst      (rst),
    .bitValid (bitValid),
    .bitIn    (bitIn),
    .detect   (detect)
  );

  function automatic logic modelDetect(logic [2:0] h, logic v, logic b);
    return v && b && (h == 3'b110);
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: detect=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    bitValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    hist = 3'b000;
  endtask

  // Drive one cycle, check detect against the model, then advance the model.
  task automatic sendBit(logic v, logic b, string req);
    logic exp;
    @(negedge clk);
    bitValid = v;
    bitIn = b;
    #1;
    exp = modelDetect(hist, v, b);
    check(req, detect, exp);
    if (v) hist = {hist[1:0], b};
  endtask

  task automatic sendStream(string bits, string req);
    for (int i = 0; i < bits.len(); i++)
      sendBit(1'b1, bits[i] == "1", req);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finishRun();
  end

  initial begin
    doReset();
    // R1: reset state, no detect with strobe low
    #1;
    check("R1", detect, 1'b0);

    // R8: overlapping matches at positions 4 and 7
    sendStream("1101101", "R8");
    doReset();
    sendStream("1101101101", "R8");

    // R2 / R3: zeros before and between ones
    doReset();
    sendStream("0001011101", "R3");
    // R4: long run of ones then 0,1
    doReset();
    sendStream("11111101", "R4");
    // R5: 0 in tail state returns to idle
    doReset();
    sendStream("11001101", "R5");
    // R2: 1001 must not match
    doReset();
    sendStream("10011001", "R2");

    // R1: reset mid-pattern forgets "110"
    doReset();
    sendStream("110", "R1");
    doReset();
    sendBit(1'b1, 1'b1, "R1");
    check("R1", detect, 1'b0);

    // R7: gaps inside a pattern with data 1 on idle cycles
    doReset();
    sendBit(1'b1, 1'b1, "R7");
    sendBit(1'b0, 1'b0, "R7");
    sendBit(1'b1, 1'b1, "R7");
    sendBit(1'b0, 1'b1, "R7");
    sendBit(1'b1, 1'b0, "R7");
    sendBit(1'b0, 1'b1, "R7");
    sendBit(1'b0, 1'b1, "R7");
    sendBit(1'b1, 1'b1, "R7");

    // R6: biased random stream with gaps, fixed seed
    doReset();
    void'($urandom(32'h1d0d));
    for (int n = 0; n < 3000; n++) begin
      logic v;
      logic b;
      v = ($urandom % 4) != 0;
      b = ($urandom % 3) != 0;
      sendBit(v, b, v ? "R6" : "R7");
    end

    finishRun();
  end

endmodule